// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Acknowledge

This block gathers up to 32 level-sensitive interrupt requests and assigns each one a 3-bit priority level through four 32-bit control registers. Every control register holds eight 4-bit fields. In each field the low three bits are the source's level and the top bit is a per-field write strobe. A field changes only when that strobe bit is 1 in the written data, so software can reprogram one source without a read-modify-write.

The processor reads and writes the registers through a simple single-cycle register port. When it takes an interrupt at some level, it pulses an acknowledge request carrying that level. One cycle later the block returns a valid flag and an 8-bit vector. The vector's upper three bits come from a software-written vector-base register. Its lower five bits are the number of the winning source: the highest-numbered source that is pending and programmed to the requested level. If no pending source matches, a fixed spurious vector is returned. Level 0 masks a source.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all levels, the pending register and the vector base are 0, `ack_valid` is 0 and `reg_rdata` is 0.
- R2: The control registers sit at byte offsets 0x20, 0x24, 0x28 and 0x2C, with register n at 0x20 + 4n.
- R3: On a write to a control register, field f (bits 4f+3..4f) takes the level bits 4f+2..4f from the data only when bit 4f+3 of the data is 1. Otherwise the field keeps its old level.
- R4: A read returns data in `reg_rdata` on the cycle after `reg_rd`, and `reg_rdata` is 0 when no read was made. A control register reads back its levels with every bit 4f+3 at 0. An unmapped offset reads 0.
- R5: Source x takes its level from control register (31 − x) / 8, field x mod 8.
- R6: The pending register at offset 0x34 samples `irq_in` on every clock, so bit x reflects source x one cycle late. It is read-only, and writes to it change nothing.
- R7: The vector base at offset 0x30 is an 8-bit read/write register, read back in bits 7..0.
- R8: `ack_valid` is high on exactly the cycle after each cycle with `ack_req` high. `ack_vec` is 0 when `ack_valid` is low.
- R9: An acknowledge at level L selects the highest-numbered source that is pending and whose level equals L. It returns `{vector_base[7:5], source[4:0]}`, using the register state from before the request edge.
- R10: If no pending source has level L, the acknowledge returns vector 0x18.
- R11: A source at level 0 is never selected, so a request at level 0 always returns 0x18.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after `reg_rd` |
| irq_in | input | 32 | Level-sensitive interrupt requests, one bit per source |
| ack_req | input | 1 | One-cycle acknowledge request |
| ack_lvl | input | 3 | Level being acknowledged |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_vec | output | 8 | Returned interrupt vector |

## Verification
Directed patterns try three kinds of acknowledge. In the first, several pending sources share the requested level, which shows whether the scan order favours the higher index. In the second, pending sources sit at other levels, which shows level matching apart from plain pending detection. In the third, pending sources are programmed to level 0 or a level-0 request is made, which shows masking apart from the spurious path. Control writes with mixed strobe bits tell a per-field update apart from a whole-word update. A long pseudo-random run then mixes writes, reads, changing request inputs and acknowledges at every level against the bench's reference model.

// File: rtl/irqc_pkg.sv
// Package: shared sizes, register offsets and types of the interrupt controller.
// Assumes a 32-bit register port and a source count that fills whole registers.
package irqc_pkg;
    localparam int NSRC      = 32;
    localparam int DATA_W    = 32;
    localparam int FLD_W     = 4;
    localparam int LVL_W     = FLD_W - 1;
    localparam int FPR       = DATA_W / FLD_W;         // fields per register
    localparam int NREG      = NSRC / FPR;
    localparam int REG_IW    = $clog2(NREG);
    localparam int SRC_W     = $clog2(NSRC);
    localparam int VEC_W     = 8;
    localparam int ADDR_W    = 8;
    localparam logic [ADDR_W-1:0] CTRL_BASE = 8'h20;
    localparam logic [ADDR_W-1:0] VBASE_OFS = 8'h30;
    localparam logic [ADDR_W-1:0] PEND_OFS  = 8'h34;
    localparam logic [VEC_W-1:0]  SPUR_VEC  = 8'h18;

    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/irqc_level_regs.sv
// Module: level registers. Holds NREG control registers of FPR fields each.
// A field's level updates only if its strobe bit is 1 in the written word.
// Also presents the levels per source in source order.
// Assumes wr_en is already qualified by an address decode.
module irqc_level_regs
    import irqc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_IW-1:0]     wr_idx,
    input  word_t                 wdata,
    output word_t                 reg_view [NREG],
    output logic [NSRC*LVL_W-1:0] src_lvl
);
    lvl_t lvl_q [NREG][FPR];

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        for (genvar f = 0; f < FPR; f++) begin : g_fld
            // Purpose: update one level field when its strobe bit is set.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    lvl_q[r][f] <= '0;
                else if (wr_en && wr_idx == REG_IW'(r) && wdata[f*FLD_W + LVL_W])
                    lvl_q[r][f] <= wdata[f*FLD_W +: LVL_W];
            end

            // Present the field with its strobe bit as 0.
            assign reg_view[r][f*FLD_W +: FLD_W] = {1'b0, lvl_q[r][f]};
            // Source number served by this field (R5).
            assign src_lvl[((NREG-1-r)*FPR + f)*LVL_W +: LVL_W] = lvl_q[r][f];

            a_r3_field_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_idx == REG_IW'(r) && !wdata[f*FLD_W + LVL_W]) |=> $stable(lvl_q[r][f]))
                else $error("r3: field changed with strobe bit low");
            a_r3_field_take: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_idx == REG_IW'(r) && wdata[f*FLD_W + LVL_W])
                |=> lvl_q[r][f] == $past(wdata[f*FLD_W +: LVL_W]))
                else $error("r3: field ignored strobed write");
        end
    end
endmodule

// File: rtl/irqc_pending.sv
// Module: pending register. Samples the level-sensitive request lines each
// clock. Assumes the inputs are synchronous to clk.
module irqc_pending
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_in,
    output logic [NSRC-1:0] pend_q
);
    // Purpose: register the request lines.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= irq_in;
    end

    a_r6_tracks_input: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pend_q == $past(irq_in))
        else $error("r6: pending register missed its input");
endmodule

// File: rtl/irqc_ack.sv
// Module: acknowledge scan. Finds the highest-numbered pending source whose
// level equals the requested level (level 0 never matches), then registers
// the vector and a valid flag one cycle after the request.
module irqc_ack
    import irqc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ack_req,
    input  lvl_t                  ack_lvl,
    input  logic [NSRC-1:0]       pend,
    input  logic [NSRC*LVL_W-1:0] src_lvl,
    input  logic [VEC_W-1:0]      vbase,
    output logic                  ack_valid,
    output logic [VEC_W-1:0]      ack_vec
);
    logic             found;
    logic [SRC_W-1:0] sel;
    logic             hit_q;

    // Purpose: priority scan, a later (higher) index overrides a lower one.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int x = 0; x < NSRC; x++) begin
            if (pend[x] && ack_lvl != '0 && src_lvl[x*LVL_W +: LVL_W] == ack_lvl) begin
                found = 1'b1;
                sel   = SRC_W'(x);
            end
        end
    end

    // Purpose: register the acknowledge result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid <= 1'b0;
            ack_vec   <= '0;
            hit_q     <= 1'b0;
        end else begin
            ack_valid <= ack_req;
            hit_q     <= ack_req && found;
            if (!ack_req)   ack_vec <= '0;
            else if (found) ack_vec <= {vbase[VEC_W-1:SRC_W], sel};
            else            ack_vec <= SPUR_VEC;
        end
    end

    a_r8_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> ack_valid)
        else $error("r8: missing valid");
    a_r8_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_req |=> (!ack_valid && ack_vec == '0))
        else $error("r8: stray valid");
    a_r11_level0_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && ack_lvl == '0) |=> ack_vec == SPUR_VEC)
        else $error("r11: level 0 selected a source");
    a_r9_base_bits: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |-> ack_vec[VEC_W-1:SRC_W] == $past(vbase[VEC_W-1:SRC_W]))
        else $error("r9: vector upper bits not from base");
endmodule

// File: rtl/irq_prio_ctrl.sv
// Module: prioritized interrupt controller top. Decodes the register port,
// holds the vector base, muxes the registered read data and joins the level
// registers, pending register and acknowledge scan.
// Assumes single-cycle register accesses aligned to 32-bit words.
module irq_prio_ctrl
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [31:0]       irq_in,
    input  logic              ack_req,
    input  logic [2:0]        ack_lvl,
    output logic              ack_valid,
    output logic [7:0]        ack_vec
);
    logic [ADDR_W-1:0]     ctrl_off;
    logic                  ctrl_hit;
    logic [REG_IW-1:0]     ctrl_idx;
    word_t                 reg_view [NREG];
    logic [NSRC*LVL_W-1:0] src_lvl;
    logic [NSRC-1:0]       pend_q;
    logic [VEC_W-1:0]      vbase_q;
    word_t                 rd_mux;

    // Decode of the control register window (R2).
    assign ctrl_off = reg_addr - CTRL_BASE;
    assign ctrl_hit = (reg_addr >= CTRL_BASE) && (ctrl_off < ADDR_W'(NREG*4))
                      && (reg_addr[1:0] == 2'b00);
    assign ctrl_idx = ctrl_off[2 +: REG_IW];

    irqc_level_regs u_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr && ctrl_hit),
        .wr_idx   (ctrl_idx),
        .wdata    (reg_wdata),
        .reg_view (reg_view),
        .src_lvl  (src_lvl)
    );

    irqc_pending u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_in (irq_in),
        .pend_q (pend_q)
    );

    irqc_ack u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_req   (ack_req),
        .ack_lvl   (ack_lvl),
        .pend      (pend_q),
        .src_lvl   (src_lvl),
        .vbase     (vbase_q),
        .ack_valid (ack_valid),
        .ack_vec   (ack_vec)
    );

    // Purpose: hold the software-written vector base.
    always_ff @(posedge clk) begin
        if (!rst_n)                              vbase_q <= '0;
        else if (reg_wr && reg_addr == VBASE_OFS) vbase_q <= reg_wdata[VEC_W-1:0];
    end

    // Purpose: select the word for the addressed register.
    always_comb begin
        rd_mux = '0;
        if (ctrl_hit)                   rd_mux = reg_view[ctrl_idx];
        else if (reg_addr == PEND_OFS)  rd_mux = pend_q;
        else if (reg_addr == VBASE_OFS) rd_mux = DATA_W'(vbase_q);
    end

    // Purpose: register read data, zero when no read was made.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
        else             reg_rdata <= '0;
    end

    a_r4_strobe_bits_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && ctrl_hit) |=> (reg_rdata & 32'h8888_8888) == '0)
        else $error("r4: strobe bits read back as 1");
    a_r4_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> reg_rdata == '0)
        else $error("r4: read data without a read");
endmodule

// File: tb/irq_prio_ctrl_test.sv
// Bench: behavioural reference model compared with the design every clock.
module irq_prio_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] irq_in = '0;
    logic        ack_req = 1'b0;
    logic [2:0]  ack_lvl = '0;
    logic        ack_valid;
    logic [7:0]  ack_vec;

    always #5 clk = ~clk;

    irq_prio_ctrl uut (.*);

    // Reference model state.
    int          m_lvl [32];
    logic [31:0] m_pend;
    logic [7:0]  m_vb;
    logic        e_valid;
    logic [7:0]  e_vec;
    logic [31:0] e_rdata;
    int          checks = 0, fails = 0, cycles = 0;
    string       cur_req = "R1";
    logic        done = 1'b0;

    function automatic logic [31:0] ctrl_word(int r);
        logic [31:0] w = '0;
        for (int x = 0; x < 32; x++)
            if ((31 - x) / 8 == r) w[4*(x%8) +: 3] = 3'(m_lvl[x]);
        return w;
    endfunction

    // Model: outputs from the state before the edge, then state update.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int x = 0; x < 32; x++) m_lvl[x] = 0;
            m_pend = '0; m_vb = '0;
            e_valid = 0; e_vec = '0; e_rdata = '0;
        end else begin
            e_valid = ack_req;
            e_vec   = '0;
            if (ack_req) begin
                e_vec = 8'h18;
                for (int x = 31; x >= 0; x--)
                    if (m_pend[x] && ack_lvl != 0 && m_lvl[x] == int'(ack_lvl)) begin
                        e_vec = {m_vb[7:5], 5'(x)};
                        break;
                    end
            end
            e_rdata = '0;
            if (reg_rd) begin
                if (reg_addr >= 8'h20 && reg_addr <= 8'h2C && reg_addr[1:0] == 0)
                    e_rdata = ctrl_word((int'(reg_addr) - 32) / 4);
                else if (reg_addr == 8'h34) e_rdata = m_pend;
                else if (reg_addr == 8'h30) e_rdata = {24'h0, m_vb};
            end
            if (reg_wr && reg_addr >= 8'h20 && reg_addr <= 8'h2C && reg_addr[1:0] == 0)
                for (int x = 0; x < 32; x++)
                    if ((31 - x) / 8 == (int'(reg_addr) - 32) / 4 && reg_wdata[4*(x%8)+3])
                        m_lvl[x] = int'(reg_wdata[4*(x%8) +: 3]);
            if (reg_wr && reg_addr == 8'h30) m_vb = reg_wdata[7:0];
            m_pend = irq_in;
        end
    end

    task automatic report;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // Comparison away from the active edge, plus the watchdog.
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual cycles %0d expected below 150000", cycles);
            report();
        end
        if (cycles > 1 && !done) begin
            checks++;
            if (ack_valid !== e_valid) begin
                fails++;
                $display("FAIL %s ack_valid: actual %b expected %b", cur_req, ack_valid, e_valid);
            end
            checks++;
            if (ack_vec !== e_vec) begin
                fails++;
                $display("FAIL %s ack_vec: actual %h expected %h", cur_req, ack_vec, e_vec);
            end
            checks++;
            if (reg_rdata !== e_rdata) begin
                fails++;
                $display("FAIL %s reg_rdata: actual %h expected %h", cur_req, reg_rdata, e_rdata);
            end
        end
    end

    task automatic idle;
        @(negedge clk);
        reg_wr = 0; reg_rd = 0; ack_req = 0;
    endtask
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_rd = 0; ack_req = 0; reg_addr = a; reg_wdata = d;
    endtask
    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        reg_wr = 0; reg_rd = 1; ack_req = 0; reg_addr = a;
    endtask
    task automatic ack(input logic [2:0] l);
        @(negedge clk);
        reg_wr = 0; reg_rd = 0; ack_req = 1; ack_lvl = l;
    endtask

    logic [31:0] lf = 32'h1D2C_3B4A;
    task automatic step_lf;
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
    endtask

    initial begin
        irq_in = 32'hFFFF_0000;          // R1: reset must hide this
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R1";
        rd(8'h20); rd(8'h2C); rd(8'h34); rd(8'h30); ack(3'd1); idle;

        cur_req = "R2";                  // word offsets of the four registers
        for (int r = 0; r < 4; r++) wr(8'(8'h20 + 4*r), 32'h9999_9999 + 32'(r));
        for (int r = 0; r < 4; r++) rd(8'(8'h20 + 4*r));
        rd(8'h22); rd(8'h1C); rd(8'h3C);  // R4: unaligned and unmapped read 0

        cur_req = "R3";                  // mixed strobe bits
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h20, 32'h0A8B_0C8D); rd(8'h20);
        wr(8'h24, 32'h7777_7777); rd(8'h24);
        wr(8'h24, 32'h8000_000F); rd(8'h24);

        cur_req = "R7";
        wr(8'h30, 32'h1234_56E5); rd(8'h30);

        cur_req = "R6";
        irq_in = 32'hA5A5_0F0F; idle; rd(8'h34);
        wr(8'h34, 32'h0); rd(8'h34);
        irq_in = 32'h0000_0001; rd(8'h34); rd(8'h34);

        cur_req = "R5";                  // reg0 sources 31..24 levels 7..0
        wr(8'h20, 32'hFEDC_BA98);
        wr(8'h24, 32'h9999_9999);        // sources 23..16 level 1
        wr(8'h28, 32'hABAB_ABAB);        // sources 15..8 levels 2/3
        wr(8'h2C, 32'h8888_8888);        // sources 7..0 level 0
        irq_in = 32'hFF00_0000;
        for (int l = 1; l < 8; l++) ack(3'(l));

        cur_req = "R9";                  // several share a level
        irq_in = 32'h0091_0000; idle; ack(3'd1);
        irq_in = 32'h0001_0000; idle; ack(3'd1);
        irq_in = 32'h0000_FF00; idle; ack(3'd2); ack(3'd3);
        ack(3'd1); wr(8'h24, 32'h0000_0008); ack(3'd1);  // old state at edge

        cur_req = "R10";
        irq_in = 32'h0000_FF00; idle; ack(3'd5);
        irq_in = 32'h0; idle; ack(3'd2);

        cur_req = "R11";
        irq_in = 32'h0100_00FF; idle; ack(3'd0); ack(3'd1);

        cur_req = "R8";
        ack(3'd2); idle; ack(3'd3); ack(3'd3); idle;

        cur_req = "R9";                  // pseudo-random mix
        for (int i = 0; i < 4000; i++) begin
            step_lf;
            case (lf[2:0])
                3'd0:    wr(8'(8'h20 + 4*lf[4:3]), lf ^ {lf[15:0], lf[31:16]});
                3'd1:    rd(8'(8'h20 + 4*lf[4:3]));
                3'd2:    begin irq_in = lf & {lf[7:0], lf[31:8]}; idle; end
                3'd3:    wr(8'h30, lf);
                default: ack(lf[10:8]);
            endcase
        end
        idle; idle;
        done = 1;
        report();
    end
endmodule